// File: doc/BRIEF.md
# Interrupt and Bus Request Arbiter

This block sits next to a small 8-bit CPU sequencer and decides which pending event is serviced next. It watches an active-low external bus request, an edge-triggered nonmaskable interrupt and a set of level-sensitive maskable interrupt lines. It also watches two boundary pulses from the sequencer: one at the end of every machine cycle and one at the end of every instruction.

A bus request is only taken at a machine-cycle boundary. Taking it asserts the bus acknowledge, stalls the CPU and turns off the output enable for the address, data and control buses. Interrupts are only arbitrated at an instruction boundary, in a fixed order: NMI, then INT0, then INT1, then INT2. A winning interrupt is reported as a one-hot grant that lasts for one clock. INT0 additionally pulses the M1 and IORQ strobes of the acknowledge cycle. All pins are plain control signals with no valid/ready flow: the boundary pulses are single-cycle and the sequencer never stalls the arbiter.

Top module: `evt_arbiter`

## Requirements
- R1: Bus request is recognised only on a clock where `mc_end` is high. `busack_n` goes low on the rising edge that samples `mc_end` while the synchronised request is active. A pulse on `ins_end` alone never takes the bus.
- R2: While `busack_n` is low, `bus_oe` is 0 (buses high-impedance). No grant is issued and the boundary pulses are ignored.
- R3: After `busreq_n` returns high, `busack_n` stays low for two more rising edges (synchroniser) and rises on the third. `bus_oe` returns to 1 at the same time. Arbitration then resumes at the next boundary, and interrupts still pending are served there.
- R4: A falling edge on `nmi_n` is latched as pending until it is granted, even if `nmi_n` has already returned high. Several edges arriving before the grant merge into a single grant.
- R5: Priority at an instruction boundary is: bus request (when `mc_end` is also high), then NMI, then INT0, then INT1, then INT2. At most one source wins per boundary.
- R6: Maskable lines are level-sensitive and low-active. Line k takes part only while `irq_en[k]` is 1, and a line held low is granted again at every boundary it wins.
- R7: `grant` encoding: bit 0 NMI, bit 1 INT0, bit 2 INT1, bit 3 INT2. It is one-hot and high for exactly one clock, starting on the rising edge that samples `ins_end`.
- R8: An INT0 grant drives `m1_n` and `iorq_n` low in the same cycle as the grant. NMI, INT1 and INT2 grants leave both strobes high.
- R9: During reset, `bus_oe` is 0, `busack_n` is 1, `grant` is 0 and both strobes are 1. `bus_oe` rises after the first clock edge out of reset.
- R10: Interrupts are not arbitrated on an `mc_end` pulse without `ins_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busreq_n | input | 1 | External bus request, active low, asynchronous |
| nmi_n | input | 1 | Nonmaskable interrupt, falling-edge triggered |
| irq_n | input | N_IRQ (3) | Maskable interrupt lines, active low; bit 0 is INT0 |
| irq_en | input | N_IRQ (3) | Per-line enable for the maskable lines |
| mc_end | input | 1 | One-cycle pulse at the end of a machine cycle |
| ins_end | input | 1 | One-cycle pulse at the end of an instruction |
| busack_n | output | 1 | Bus acknowledge, active low |
| bus_oe | output | 1 | Output enable for address, data and control buses (0 = high-Z) |
| grant | output | N_IRQ+1 (4) | One-hot grant of the serviced interrupt |
| m1_n | output | 1 | M1 strobe of the INT0 acknowledge cycle, active low |
| iorq_n | output | 1 | IORQ strobe of the INT0 acknowledge cycle, active low |

## Verification
Each maskable line is first driven alone, which ties every grant bit and the presence or absence of the strobes to a single source. Pairs and triples of simultaneous requests are then applied to separate the priority order, and a disabled line is paired with an enabled lower one to separate masking from priority. NMI pulses that end before the boundary, and double pulses, distinguish edge latching and merging from level sampling. Bus requests are presented with instruction-only, machine-cycle-only and combined boundaries, with interrupts waiting behind them, to tell the two sampling points apart and to measure the release latency.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
  typedef enum logic {
    ARB_RUN = 1'b0,
    ARB_BUS = 1'b1
  } arb_state_t;

  // grant bit positions (order of the arbitration chain, bit 0 wins)
  localparam int GNT_NMI  = 0;
  localparam int GNT_INT0 = 1;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int   WIDTH     = 1,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {STAGES{{WIDTH{RESET_VAL}}}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/evt_nmi_latch.sv
module evt_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_n,
  input  logic ack,
  output logic pend
);
  logic prev_n;
  logic fall;

  assign fall = prev_n & ~lvl_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_n <= lvl_n;
      // a fresh edge wins over a same-cycle acknowledge; repeats merge
      pend   <= (pend & ~ack) | fall;
    end
  end
endmodule

// File: rtl/evt_prio_sel.sv
module evt_prio_sel #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] sel
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign sel[i]       = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_arb_pkg::*;
#(
  parameter int N_IRQ       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busreq_n,
  input  logic             nmi_n,
  input  logic [N_IRQ-1:0] irq_n,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             mc_end,
  input  logic             ins_end,
  output logic             busack_n,
  output logic             bus_oe,
  output logic [N_IRQ:0]   grant,
  output logic             m1_n,
  output logic             iorq_n
);
  localparam int NSRC  = N_IRQ + 1;
  localparam int NSYNC = N_IRQ + 2;

  logic [NSYNC-1:0] raw_n;
  logic [NSYNC-1:0] syn_n;
  logic             busreq_s;
  logic             nmi_lvl_n;
  logic [N_IRQ-1:0] irq_s;
  logic             nmi_pend;
  logic             nmi_ack;
  logic [NSRC-1:0]  req_vec;
  logic [NSRC-1:0]  win;

  arb_state_t       st_q, st_d;
  logic             issue;
  logic             busack_q;
  logic             oe_q;
  logic [NSRC-1:0]  grant_q;
  logic             ack0_q;

  assign raw_n = {irq_n, nmi_n, busreq_n};

  evt_sync #(
    .WIDTH    (NSYNC),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_n),
    .q    (syn_n)
  );

  assign busreq_s  = ~syn_n[0];
  assign nmi_lvl_n = syn_n[1];
  assign irq_s     = ~syn_n[NSYNC-1:2] & irq_en;

  evt_nmi_latch u_nmi (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl_n(nmi_lvl_n),
    .ack  (nmi_ack),
    .pend (nmi_pend)
  );

  assign req_vec = {irq_s, nmi_pend};

  evt_prio_sel #(.N(NSRC)) u_prio (
    .req(req_vec),
    .sel(win)
  );

  always_comb begin
    st_d  = st_q;
    issue = 1'b0;
    unique case (st_q)
      ARB_RUN: begin
        if (mc_end && busreq_s) begin
          st_d = ARB_BUS;
        end else if (ins_end && (|req_vec)) begin
          issue = 1'b1;
        end
      end
      ARB_BUS: begin
        if (!busreq_s) st_d = ARB_RUN;
      end
      default: st_d = ARB_RUN;
    endcase
  end

  assign nmi_ack = issue & win[GNT_NMI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ARB_RUN;
      busack_q <= 1'b0;
      oe_q     <= 1'b0;
      grant_q  <= '0;
      ack0_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      busack_q <= (st_d == ARB_BUS);
      oe_q     <= (st_d != ARB_BUS);
      grant_q  <= issue ? win : '0;
      ack0_q   <= issue & win[GNT_INT0];
    end
  end

  assign busack_n = ~busack_q;
  assign bus_oe   = oe_q;
  assign grant    = grant_q;
  assign m1_n     = ~ack0_q;
  assign iorq_n   = ~ack0_q;
endmodule

// File: rtl/evt_arbiter_chk.sv
module evt_arbiter_chk #(
  parameter int N_IRQ = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mc_end,
  input logic           ins_end,
  input logic           busack_n,
  input logic           bus_oe,
  input logic [N_IRQ:0] grant,
  input logic           m1_n,
  input logic           iorq_n
);
  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= !rst_n;

  // R9
  always_ff @(posedge clk) begin
    if (!rst_n && rst_seen) begin
      reset_hiz_chk: assert (!bus_oe && busack_n && grant == '0 && m1_n && iorq_n)
        else $error("reset state wrong");
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  grant_after_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> $past(ins_end));

  // R8
  int0_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant[1] |-> (!m1_n && !iorq_n));

  // R8
  other_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant[1] |-> (m1_n && iorq_n));

  // R1
  busack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busack_n) |-> $past(mc_end));

  // R2
  busack_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busack_n |-> !bus_oe);

  // R2
  no_grant_in_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busack_n && $past(!busack_n)) |-> (grant == '0));
endmodule

bind evt_arbiter evt_arbiter_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mc_end  (mc_end),
  .ins_end (ins_end),
  .busack_n(busack_n),
  .bus_oe  (bus_oe),
  .grant   (grant),
  .m1_n    (m1_n),
  .iorq_n  (iorq_n)
);

// File: tb/tb_evt_arbiter.sv
`timescale 1ns/1ps
module tb_evt_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busreq_n = 1'b1;
  logic       nmi_n = 1'b1;
  logic [2:0] irq_n = 3'b111;
  logic [2:0] irq_en = 3'b111;
  logic       mc_end = 1'b0;
  logic       ins_end = 1'b0;
  logic       busack_n;
  logic       bus_oe;
  logic [3:0] grant;
  logic       m1_n;
  logic       iorq_n;

  int checks = 0;
  int failures = 0;

  // item = {grant, m1_n, iorq_n}
  logic [5:0] exp_q[$];

  localparam logic [3:0] G_NMI  = 4'b0001;
  localparam logic [3:0] G_INT0 = 4'b0010;
  localparam logic [3:0] G_INT1 = 4'b0100;
  localparam logic [3:0] G_INT2 = 4'b1000;

  evt_arbiter dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .busreq_n(busreq_n),
    .nmi_n   (nmi_n),
    .irq_n   (irq_n),
    .irq_en  (irq_en),
    .mc_end  (mc_end),
    .ins_end (ins_end),
    .busack_n(busack_n),
    .bus_oe  (bus_oe),
    .grant   (grant),
    .m1_n    (m1_n),
    .iorq_n  (iorq_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // queue the expected grant plus strobes (R8: only INT0 pulls them low)
  task automatic expect_grant(input logic [3:0] g);
    logic s;
    s = (g == G_INT0) ? 1'b0 : 1'b1;
    exp_q.push_back({g, s, s});
  endtask

  // one-cycle boundary pulse; returns at the negedge after the sampling edge
  task automatic boundary(input logic ins, input logic mc);
    @(negedge clk);
    ins_end = ins;
    mc_end  = mc;
    @(negedge clk);
    ins_end = 1'b0;
    mc_end  = 1'b0;
  endtask

  // monitor: every observed grant must match the head of the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && grant !== 4'b0000) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected grant", {2'b0, grant, m1_n, iorq_n}, 8'h0);
        end else begin
          logic [5:0] it;
          it = exp_q.pop_front();
          chk({grant, m1_n, iorq_n} === it, "R7/R8 grant and strobes",
              {2'b0, grant, m1_n, iorq_n}, {2'b0, it});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cycles(3);
    // R9 reset state
    chk(bus_oe == 1'b0, "R9 bus_oe in reset", {7'b0, bus_oe}, 8'h0);
    chk({busack_n, m1_n, iorq_n} == 3'b111 && grant == 4'b0, "R9 outputs in reset",
        {1'b0, grant, busack_n, m1_n, iorq_n}, 8'h07);
    rst_n = 1'b1;
    cycles(2);
    chk(bus_oe == 1'b1, "R9 bus_oe after reset", {7'b0, bus_oe}, 8'h1);

    // R6/R7/R8 single sources
    irq_n = 3'b110; cycles(4); expect_grant(G_INT0); boundary(1, 1);
    irq_n = 3'b111; cycles(4);
    irq_n = 3'b101; cycles(4); expect_grant(G_INT1); boundary(1, 1);
    irq_n = 3'b111; cycles(4);
    irq_n = 3'b011; cycles(4); expect_grant(G_INT2); boundary(1, 1);
    irq_n = 3'b111; cycles(4);

    // R5 priority among maskable lines
    irq_n = 3'b001; cycles(4); expect_grant(G_INT1); boundary(1, 1);
    irq_n = 3'b100; cycles(4); expect_grant(G_INT0); boundary(1, 1);
    irq_n = 3'b111; cycles(4);

    // R6 level-sensitive: held line wins again
    irq_n = 3'b011; cycles(4);
    expect_grant(G_INT2); boundary(1, 1);
    expect_grant(G_INT2); boundary(1, 1);
    irq_n = 3'b111; cycles(4);

    // R6 masking: disabled INT1 with enabled INT2
    irq_en = 3'b101;
    irq_n  = 3'b001; cycles(4); expect_grant(G_INT2); boundary(1, 1);
    irq_n  = 3'b101; cycles(4); boundary(1, 1);
    chk(grant == 4'b0, "R6 masked line granted", {4'b0, grant}, 8'h0);
    irq_n = 3'b111; irq_en = 3'b111; cycles(4);

    // R10 no interrupt arbitration on mc_end alone
    irq_n = 3'b110; cycles(4); boundary(0, 1);
    chk(grant == 4'b0, "R10 grant on mc_end only", {4'b0, grant}, 8'h0);
    expect_grant(G_INT0); boundary(1, 1);
    irq_n = 3'b111; cycles(4);

    // R4 NMI pulse ended before boundary, then merge of two edges
    nmi_n = 1'b0; cycles(5); nmi_n = 1'b1; cycles(4);
    expect_grant(G_NMI); boundary(1, 1);
    nmi_n = 1'b0; cycles(4); nmi_n = 1'b1; cycles(4);
    nmi_n = 1'b0; cycles(4); nmi_n = 1'b1; cycles(4);
    expect_grant(G_NMI); boundary(1, 1);
    boundary(1, 1);
    chk(grant == 4'b0, "R4 merged edges gave second grant", {4'b0, grant}, 8'h0);

    // R5 NMI over INT0
    irq_n = 3'b110; nmi_n = 1'b0; cycles(5); nmi_n = 1'b1; cycles(2);
    expect_grant(G_NMI);  boundary(1, 1);
    expect_grant(G_INT0); boundary(1, 1);
    irq_n = 3'b111; cycles(4);

    // R1 bus request needs mc_end
    busreq_n = 1'b0; cycles(4); boundary(1, 0);
    chk(busack_n == 1'b1, "R1 bus taken on ins_end only", {7'b0, busack_n}, 8'h1);
    boundary(0, 1);
    chk(busack_n == 1'b0, "R1 busack after mc_end", {7'b0, busack_n}, 8'h0);
    // R2 buses released to high-Z, boundaries ignored
    chk(bus_oe == 1'b0, "R2 bus_oe while granted", {7'b0, bus_oe}, 8'h0);
    irq_n = 3'b110; cycles(4); boundary(1, 1);
    chk(grant == 4'b0 && busack_n == 1'b0, "R2 grant during bus ownership",
        {3'b0, grant, busack_n}, 8'h0);
    // R3 release latency
    @(negedge clk); busreq_n = 1'b1;
    cycles(2);
    chk(busack_n == 1'b0, "R3 busack released early", {7'b0, busack_n}, 8'h0);
    cycles(1);
    chk(busack_n == 1'b1 && bus_oe == 1'b1, "R3 busack release",
        {6'b0, busack_n, bus_oe}, 8'h3);
    expect_grant(G_INT0); boundary(1, 1);
    irq_n = 3'b111; cycles(4);

    // R5 bus request beats a pending interrupt at a combined boundary
    busreq_n = 1'b0; irq_n = 3'b011; cycles(4); boundary(1, 1);
    chk(busack_n == 1'b0 && grant == 4'b0, "R5 bus over interrupt",
        {3'b0, grant, busack_n}, 8'h0);
    busreq_n = 1'b1; cycles(5);
    expect_grant(G_INT2); boundary(1, 1);
    irq_n = 3'b111; cycles(4);

    chk(exp_q.size() == 0, "R7 missing grants", 8'(exp_q.size()), 8'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule